// File: doc/BRIEF.md
# Privileged Special-Register Access Unit

This block executes the two special-register move operations of a processor core: reading a special register into the datapath and writing a datapath value into a special register. Each cycle the pipeline presents a read strobe, a write strobe, a 16-bit register address, the write value, and two privilege bits taken from the status word. The unit decides whether the access is legal and, if it is, returns the register value or updates the register. An illegal access raises a warning output and has no other effect.

The address is built from a group number in bits above position 11 and an index within the group. The system group (0) holds the identity words, the status word, the program-counter views, the FP status word, the exception save registers and a 512-slot shadow general-register window starting at index 1024. Group 5 holds the accumulator halves, and group 10 holds the tick-timer mode word, which only accepts zero. Reads return data combinationally in the same cycle, and writes take effect at the next rising clock edge. A write to the next-PC address stores nothing. Instead, one cycle later it emits a redirect pulse that carries the target address and a delay-slot clear.

Top module: `spr_access_unit`

## Requirements
- R1: An access is permitted only when `sup_mode` or `user_spr_en` is 1. A denied read returns 0, a denied write changes no register and issues no redirect, and both raise `warn`.
- R2: Any address at or above `NUM_SPR` (default 22528) is invalid. A read of it returns 0, and a read or write of it raises `warn`.
- R3: The version (addr 0), unit-present (1) and configuration (2) words read back their parameter values. The previous-PC address (18) reads back the `prev_pc` input, with `warn` low.
- R4: The next-PC (16), exception-status (64) and tick-timer (20480) addresses, and any in-range unassigned address, read 0 with `warn` high.
- R5: The FP status (20), exception-PC (32), accumulator low (10241) and accumulator high (10242) words accept writes without a warning. Each reads back the written value from the cycle after the write.
- R6: Addresses 1024 to 1535 map to 512 independent 32-bit shadow slots that can be read and written. Address 1536 is unassigned.
- R7: A write to the status word (17) stores the value with bit 15 forced to 1. The stored value appears on `sr_value` and reads back at address 17. The reset value is 0x00008000.
- R8: A permitted write to next-PC raises no warning and stores nothing. In the next cycle, `redirect_valid` and `dslot_clear` are 1 for exactly one cycle, and `redirect_pc` carries the written value.
- R9: A write of 0 to the tick-timer word raises no warning. A write of any nonzero value raises `warn`.
- R10: A write to the exception-status word raises no warning and appears on `esr_value` in the next cycle. It is not readable (see R4).
- R11: When a read and a write to the same address fall in one cycle, the read returns the value held before that write.
- R12: After reset, `esr_value`, `redirect_valid` and `dslot_clear` are 0 and `sr_value` is 0x00008000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 16 | Special-register address (group << 11 \| index) |
| wr_data | input | 32 | Write value |
| sup_mode | input | 1 | Supervisor-mode bit of the status word |
| user_spr_en | input | 1 | User special-register access enable |
| prev_pc | input | 32 | Previous-PC value from the pipeline |
| rd_data | output | 32 | Combinational read result |
| warn | output | 1 | Illegal access in this cycle |
| redirect_valid | output | 1 | One-cycle PC redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| dslot_clear | output | 1 | Clear pending delay-slot state |
| sr_value | output | 32 | Current status word |
| esr_value | output | 32 | Current exception-status word |

## Verification
A read and a write can be presented in the same cycle. The bench provokes this by raising both strobes on the exception-PC address and on a shadow slot at once. It judges the result by expecting the read to return the pre-write value, and the value read in the following cycle to be the new one. The same collision also occurs between a write to next-PC and the registered redirect of a previous write. For that case the bench checks that the redirect pulse lands exactly one cycle after the strobe and never after a denied write.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int GRP_SHIFT = 11;

  localparam int A_VER      = 0;
  localparam int A_UNITS    = 1;
  localparam int A_CFG      = 2;
  localparam int A_NEXTPC   = 16;
  localparam int A_STATUS   = 17;
  localparam int A_PREVPC   = 18;
  localparam int A_FPSTAT   = 20;
  localparam int A_EXCPC    = 32;
  localparam int A_EXCSTAT  = 64;
  localparam int A_SHADOW   = 1024;
  localparam int A_ACC_LO   = (5 << GRP_SHIFT) | 1;
  localparam int A_ACC_HI   = (5 << GRP_SHIFT) | 2;
  localparam int A_TIMERMOD = (10 << GRP_SHIFT);

  localparam int FIXED_ONE_BIT = 15;

  typedef enum logic [3:0] {
    K_NONE, K_VER, K_UNITS, K_CFG, K_STATUS, K_PREVPC, K_FPSTAT,
    K_EXCPC, K_EXCSTAT, K_ACC_LO, K_ACC_HI, K_NEXTPC, K_TIMERMOD, K_SHADOW
  } spr_kind_e;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_SPR  = 22528,
  parameter int SHADOW_N = 512,
  localparam int SH_W    = $clog2(SHADOW_N)
) (
  input  logic [ADDR_W-1:0] addr,
  output spr_kind_e         kind,
  output logic              in_range,
  output logic              readable,
  output logic              writable,
  output logic [SH_W-1:0]   shadow_idx
);
  logic [31:0] a32;
  logic [31:0] off;

  always_comb begin
    a32      = 32'(addr);
    off      = a32 - 32'(A_SHADOW);
    in_range = (a32 < 32'(NUM_SPR));
    shadow_idx = off[SH_W-1:0];
    kind = K_NONE;
    if (in_range) begin
      if (a32 >= 32'(A_SHADOW) && a32 < 32'(A_SHADOW + SHADOW_N)) kind = K_SHADOW;
      else begin
        case (a32)
          32'(A_VER):      kind = K_VER;
          32'(A_UNITS):    kind = K_UNITS;
          32'(A_CFG):      kind = K_CFG;
          32'(A_NEXTPC):   kind = K_NEXTPC;
          32'(A_STATUS):   kind = K_STATUS;
          32'(A_PREVPC):   kind = K_PREVPC;
          32'(A_FPSTAT):   kind = K_FPSTAT;
          32'(A_EXCPC):    kind = K_EXCPC;
          32'(A_EXCSTAT):  kind = K_EXCSTAT;
          32'(A_ACC_LO):   kind = K_ACC_LO;
          32'(A_ACC_HI):   kind = K_ACC_HI;
          32'(A_TIMERMOD): kind = K_TIMERMOD;
          default:         kind = K_NONE;
        endcase
      end
    end
    case (kind)
      K_VER, K_UNITS, K_CFG, K_STATUS, K_PREVPC, K_FPSTAT,
      K_EXCPC, K_ACC_LO, K_ACC_HI, K_SHADOW: readable = 1'b1;
      default:                               readable = 1'b0;
    endcase
    case (kind)
      K_FPSTAT, K_EXCPC, K_EXCSTAT, K_ACC_LO, K_ACC_HI, K_SHADOW,
      K_STATUS, K_NEXTPC, K_TIMERMOD: writable = 1'b1;
      default:                        writable = 1'b0;
    endcase
  end
endmodule

// File: rtl/spr_shadow_ram.sv
module spr_shadow_ram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/spr_regfile.sv
module spr_regfile
  import spr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] SR_RESET = DATA_W'(1) << FIXED_ONE_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  spr_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] fpstat_q,
  output logic [DATA_W-1:0] excpc_q,
  output logic [DATA_W-1:0] excstat_q,
  output logic [DATA_W-1:0] acc_lo_q,
  output logic [DATA_W-1:0] acc_hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= SR_RESET;
      fpstat_q  <= '0;
      excpc_q   <= '0;
      excstat_q <= '0;
      acc_lo_q  <= '0;
      acc_hi_q  <= '0;
    end else if (we) begin
      case (kind)
        K_STATUS: begin
          status_q <= wdata;
          status_q[FIXED_ONE_BIT] <= 1'b1;
        end
        K_FPSTAT:  fpstat_q  <= wdata;
        K_EXCPC:   excpc_q   <= wdata;
        K_EXCSTAT: excstat_q <= wdata;
        K_ACC_LO:  acc_lo_q  <= wdata;
        K_ACC_HI:  acc_hi_q  <= wdata;
        default: ;
      endcase
    end
  end

  // R7
  sr_fixed_one_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[FIXED_ONE_BIT]);

  // R10
  esr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && kind == K_EXCSTAT) |=> $stable(excstat_q));
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_SPR  = 22528,
  parameter int SHADOW_N = 512,
  parameter logic [DATA_W-1:0] VER_VAL   = 32'h1200_0001,
  parameter logic [DATA_W-1:0] UNITS_VAL = 32'h0000_0001,
  parameter logic [DATA_W-1:0] CFG_VAL   = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sup_mode,
  input  logic              user_spr_en,
  input  logic [DATA_W-1:0] prev_pc,
  output logic [DATA_W-1:0] rd_data,
  output logic              warn,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              dslot_clear,
  output logic [DATA_W-1:0] sr_value,
  output logic [DATA_W-1:0] esr_value
);
  localparam int SH_W = $clog2(SHADOW_N);

  spr_kind_e         kind;
  logic              in_range, readable, writable, priv;
  logic [SH_W-1:0]   sh_idx;
  logic              rd_ok, wr_ok, wr_bad, rd_bad, timer_nonzero;
  logic [DATA_W-1:0] sh_rdata, fpstat_q, excpc_q, acc_lo_q, acc_hi_q;
  logic [DATA_W-1:0] rd_mux;

  spr_decode #(.ADDR_W(ADDR_W), .NUM_SPR(NUM_SPR), .SHADOW_N(SHADOW_N)) u_dec (
    .addr(addr), .kind(kind), .in_range(in_range), .readable(readable),
    .writable(writable), .shadow_idx(sh_idx)
  );

  assign priv          = sup_mode | user_spr_en;
  assign timer_nonzero = (kind == K_TIMERMOD) && (wr_data != '0);
  assign rd_ok         = priv && readable;
  assign rd_bad        = !rd_ok;
  assign wr_ok         = priv && writable && !timer_nonzero;
  assign wr_bad        = !wr_ok;
  assign warn          = (rd_en && rd_bad) || (wr_en && wr_bad);

  spr_shadow_ram #(.DEPTH(SHADOW_N), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(wr_en && wr_ok && kind == K_SHADOW), .idx(sh_idx),
    .wdata(wr_data), .rdata(sh_rdata)
  );

  spr_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en && wr_ok), .kind(kind), .wdata(wr_data),
    .status_q(sr_value), .fpstat_q(fpstat_q), .excpc_q(excpc_q),
    .excstat_q(esr_value), .acc_lo_q(acc_lo_q), .acc_hi_q(acc_hi_q)
  );

  always_comb begin
    case (kind)
      K_VER:    rd_mux = VER_VAL;
      K_UNITS:  rd_mux = UNITS_VAL;
      K_CFG:    rd_mux = CFG_VAL;
      K_STATUS: rd_mux = sr_value;
      K_PREVPC: rd_mux = prev_pc;
      K_FPSTAT: rd_mux = fpstat_q;
      K_EXCPC:  rd_mux = excpc_q;
      K_ACC_LO: rd_mux = acc_lo_q;
      K_ACC_HI: rd_mux = acc_hi_q;
      K_SHADOW: rd_mux = sh_rdata;
      default:  rd_mux = '0;
    endcase
    rd_data = (rd_en && rd_ok) ? rd_mux : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      dslot_clear    <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= wr_en && wr_ok && kind == K_NEXTPC;
      dslot_clear    <= wr_en && wr_ok && kind == K_NEXTPC;
      if (wr_en && wr_ok && kind == K_NEXTPC) redirect_pc <= wr_data;
    end
  end

  // R1
  deny_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sup_mode && !user_spr_en) |-> (rd_data == '0 && warn));

  // R2
  oob_warn_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && 32'(addr) >= 32'(NUM_SPR)) |-> warn);

  // R8
  redirect_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(redirect_valid) |-> $past(wr_en && (sup_mode || user_spr_en)
      && 32'(addr) == 32'(A_NEXTPC)));

  // R8
  redirect_single_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> dslot_clear);
endmodule

// File: tb/sim_spr_access_unit.sv
module sim_spr_access_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER_V = 32'h1200_0001;
  localparam logic [31:0] UNI_V = 32'h0000_0001;
  localparam logic [31:0] CFG_V = 32'h0000_0020;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_en = 0, wr_en = 0, sup_mode = 1, user_spr_en = 0;
  logic [15:0] addr = '0;
  logic [31:0] wr_data = '0, prev_pc = 32'hDEAD_0004;
  logic [31:0] rd_data, redirect_pc, sr_value, esr_value;
  logic warn, redirect_valid, dslot_clear;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] d;
    logic        w;
    bit          chk_d;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_access_unit u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .sup_mode(sup_mode), .user_spr_en(user_spr_en),
    .prev_pc(prev_pc), .rd_data(rd_data), .warn(warn),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .dslot_clear(dslot_clear), .sr_value(sr_value), .esr_value(esr_value)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per cycle in which the driver pushed one
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.chk_d) check32({e.tag, " rd_data"}, rd_data, e.d);
      check32({e.tag, " warn"}, 32'(warn), 32'(e.w));
    end
  end

  task automatic acc(bit r, bit w, int a, logic [31:0] d,
                     logic [31:0] exp_d, logic exp_w, string tag);
    exp_t e;
    @(posedge clk); #1;
    rd_en = r; wr_en = w; addr = 16'(a); wr_data = d;
    e.d = exp_d; e.w = exp_w; e.chk_d = r; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    rd_en = 0; wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R12 reset state
    check32("R12 sr", sr_value, 32'h0000_8000);
    check32("R12 esr", esr_value, 0);
    check32("R12 redirect", 32'(redirect_valid), 0);
    check32("R12 dslot", 32'(dslot_clear), 0);

    // R3 constant and pipeline-sourced words
    acc(1, 0, 0, 0, VER_V, 0, "R3 ver");
    acc(1, 0, 1, 0, UNI_V, 0, "R3 units");
    acc(1, 0, 2, 0, CFG_V, 0, "R3 cfg");
    acc(1, 0, 18, 0, 32'hDEAD_0004, 0, "R3 prevpc");

    // R5 plain writable words
    acc(0, 1, 20, 32'h0000_0F0F, 0, 0, "R5 fp wr");
    acc(1, 0, 20, 0, 32'h0000_0F0F, 0, "R5 fp rd");
    acc(0, 1, 10241, 32'h1111_2222, 0, 0, "R5 acclo wr");
    acc(0, 1, 10242, 32'h3333_4444, 0, 0, "R5 acchi wr");
    acc(1, 0, 10241, 0, 32'h1111_2222, 0, "R5 acclo rd");
    acc(1, 0, 10242, 0, 32'h3333_4444, 0, "R5 acchi rd");

    // R11 read and write of one address in one cycle
    acc(0, 1, 32, 32'h0000_1000, 0, 0, "R5 excpc wr");
    acc(1, 1, 32, 32'h0000_2000, 32'h0000_1000, 0, "R11 excpc old");
    acc(1, 0, 32, 0, 32'h0000_2000, 0, "R11 excpc new");

    // R6 shadow window
    acc(0, 1, 1024, 32'hAAAA_0000, 0, 0, "R6 sh0 wr");
    acc(0, 1, 1535, 32'hBBBB_0511, 0, 0, "R6 sh511 wr");
    acc(1, 0, 1024, 0, 32'hAAAA_0000, 0, "R6 sh0 rd");
    acc(1, 0, 1535, 0, 32'hBBBB_0511, 0, "R6 sh511 rd");
    acc(1, 1, 1535, 32'h0000_0077, 32'hBBBB_0511, 0, "R11 sh511 old");
    acc(1, 0, 1535, 0, 32'h0000_0077, 0, "R11 sh511 new");
    acc(1, 0, 1536, 0, 0, 1, "R6 past window rd");
    acc(0, 1, 1536, 32'h5, 0, 1, "R6 past window wr");
    acc(1, 0, 1024, 0, 32'hAAAA_0000, 0, "R6 sh0 intact");

    // R7 status fixed-one bit
    acc(0, 1, 17, 32'h0000_0001, 0, 0, "R7 sr wr");
    acc(1, 0, 17, 0, 32'h0000_8001, 0, "R7 sr rd");
    check32("R7 sr_value", sr_value, 32'h0000_8001);

    // R10 exception-status
    acc(0, 1, 64, 32'h0000_0055, 0, 0, "R10 esr wr");
    acc(1, 0, 64, 0, 0, 1, "R4 esr rd");
    check32("R10 esr_value", esr_value, 32'h0000_0055);

    // R8 next-PC redirect
    acc(0, 1, 16, 32'h0000_4000, 0, 0, "R8 npc wr");
    acc(1, 0, 16, 0, 0, 1, "R4 npc rd");
    check32("R8 redirect_valid", 32'(redirect_valid), 1);
    check32("R8 dslot_clear", 32'(dslot_clear), 1);
    check32("R8 redirect_pc", redirect_pc, 32'h0000_4000);
    idle();
    check32("R8 single pulse", 32'(redirect_valid), 0);

    // R9 timer mode word
    acc(0, 1, 20480, 0, 0, 0, "R9 timer zero");
    acc(0, 1, 20480, 32'h5, 0, 1, "R9 timer nonzero");
    acc(1, 0, 20480, 0, 0, 1, "R4 timer rd");

    // R4 unassigned in-range address
    acc(1, 0, 5, 0, 0, 1, "R4 unassigned rd");
    acc(0, 1, 5, 32'h9, 0, 1, "R4 unassigned wr");

    // R2 out of range
    acc(1, 0, 22528, 0, 0, 1, "R2 first invalid rd");
    acc(0, 1, 22528, 32'h1, 0, 1, "R2 first invalid wr");
    acc(1, 0, 16'hFFFF, 0, 0, 1, "R2 top rd");
    acc(1, 0, 22527, 0, 0, 1, "R4 last in range");

    // R1 privilege gating
    idle();
    sup_mode = 0; user_spr_en = 0;
    acc(1, 0, 0, 0, 0, 1, "R1 denied rd");
    acc(0, 1, 20, 32'h0000_1234, 0, 1, "R1 denied wr");
    acc(0, 1, 16, 32'h0000_8888, 0, 1, "R1 denied npc");
    idle();
    check32("R1 no redirect", 32'(redirect_valid), 0);
    user_spr_en = 1;
    acc(1, 0, 20, 0, 32'h0000_0F0F, 0, "R1 user enable rd");
    idle();
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule